// File: doc/BRIEF.md
# Codec Frame-Sync Slave

This block is the slave half of a serial audio codec link. An external codec owns the bit clock and the frame sync line. The block watches the sync line and recognises the start of a frame according to a framing mode. Once a frame has started, it shifts whole words out on the serial data output and in from the serial data input. It keeps count of the bits in each word and the words in each frame, and presents the words on parallel ports.

All logic runs on one system clock that is much faster than the bit clock. The bit clock, sync and data lines are registered once. Their edges are found by comparing two successive samples. Software-facing buffering is left to the surrounding logic. Transmit words are offered on a parallel input with a valid flag and are taken at each word boundary. Received words appear on a parallel output with a one-cycle strobe and the index of the slot they came from.

Top module: `codec_fsync_slave`

## Requirements
- R1: With `fmt_i` = 0 (multi-channel), a high level on the sync line sampled at a bit-clock rise while idle starts a frame. Word 0's MSB is driven after the next bit-clock fall and sampled at the following rise. The frame holds `frame_words_i` words (1 to 16) of `word_len_i` bits (4 to 16).
- R2: With `fmt_i` = 1 (AC-link), a high sync level starts a frame of `frame_words_i` slots. Slot 0 is a 16-bit tag and every later slot is 20 bits; `word_len_i` is not used.
- R3: With `fmt_i` = 2 (I2S), a change of the sync line between two successive bit-clock rises starts a single word of `word_len_i` bits one bit later. Its slot index is 1 after a rising change and 0 after a falling change.
- R4: While a frame is running, sync events are ignored, except at the rise that samples the frame's last bit. A valid event there starts the next frame without a gap.
- R5: Words move MSB first. The serial output changes only after bit-clock falls (or when a frame ends), and the serial input is sampled at bit-clock rises.
- R6: Each received word raises `rx_valid_o` for exactly one clock. At the same time it presents the word right-justified on `rx_data_o`, with zeros above, and its slot index on `rx_slot_o`.
- R7: At every word start, if `tx_valid_i` is high, the low bits of `tx_data_i` (as many as the word is long) are sent and `tx_ack_o` pulses once. Otherwise zeros are sent and no acknowledge is given.
- R8: After the last bit of a frame without a new sync, `frame_active_o` and `sdo_o` return low and the block waits for the next valid sync.
- R9: After reset, `frame_active_o`, `sdo_o`, `rx_valid_o` and `tx_ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Framing mode: 0 multi-channel, 1 AC-link, 2 I2S |
| word_len_i | input | LEN_W | Bits per word (4 to 16) for multi-channel and I2S |
| frame_words_i | input | SLOT_W | Words or slots per frame (1 to 16) |
| bclk_i | input | 1 | Bit clock from the codec |
| fsync_i | input | 1 | Frame sync / word select from the codec |
| sdi_i | input | 1 | Serial data from the codec |
| sdo_o | output | 1 | Serial data to the codec |
| tx_data_i | input | DATA_W | Next transmit word, right-justified |
| tx_valid_i | input | 1 | Transmit word is ready |
| tx_ack_o | output | 1 | One-clock pulse when the transmit word is taken |
| rx_data_o | output | DATA_W | Received word, right-justified |
| rx_valid_o | output | 1 | One-clock strobe for a received word |
| rx_slot_o | output | SLOT_W | Slot index of the received word |
| frame_active_o | output | 1 | High while a frame is being transferred |

## Verification
The embedded assertions watch, on every clock, properties that do not depend on a particular frame. The bit counter counts down by one per rise whatever the sync line does mid-word. A sync seen while idle always arms a frame. The slot index stays inside the configured frame, and I2S slots follow the sync level. The serial output stays low when idle and moves only on bit-clock falls or at frame end. Receive strobes last one clock, and every acknowledge follows a valid offer. The bench's scenarios alone show the data itself: MSB-first order at both word-length limits, the AC-link tag and slot widths, zero fill on a missing transmit word, back-to-back frames triggered on the last bit, and the slot order of I2S words.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int unsigned AC_TAG_BITS  = 16;
    localparam int unsigned AC_SLOT_BITS = 20;

    typedef enum logic [1:0] {
        FMT_MULTI  = 2'd0,
        FMT_ACLINK = 2'd1,
        FMT_I2S    = 2'd2
    } fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

    // Registered view of the codec lines, with bit-clock edge strobes.
    typedef struct packed {
        logic rise;
        logic fall;
        logic fs_now;
        logic fs_prev;
        logic sd;
    } line_s;

    // True when the given mode has a sync that reacts to transitions.
    function automatic logic fmt_edge_sync(fmt_e f);
        return f == FMT_I2S;
    endfunction

endpackage

// File: rtl/cfs_line_sampler.sv
module cfs_line_sampler
    import cfs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bclk_i,
    input  logic  fsync_i,
    input  logic  sdi_i,
    output line_s line_o
);

    logic bclk_q;
    logic bclk_qq;
    logic fs_q;
    logic sd_q;
    logic fs_at_rise;
    logic rise_w;
    logic fall_w;

    assign rise_w = bclk_q & ~bclk_qq;
    assign fall_w = ~bclk_q & bclk_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q     <= 1'b0;
            bclk_qq    <= 1'b0;
            fs_q       <= 1'b0;
            sd_q       <= 1'b0;
            fs_at_rise <= 1'b0;
        end else begin
            bclk_q  <= bclk_i;
            bclk_qq <= bclk_q;
            fs_q    <= fsync_i;
            sd_q    <= sdi_i;
            if (rise_w) begin
                fs_at_rise <= fs_q;
            end
        end
    end

    always_comb begin
        line_o.rise    = rise_w;
        line_o.fall    = fall_w;
        line_o.fs_now  = fs_q;
        line_o.fs_prev = fs_at_rise;
        line_o.sd      = sd_q;
    end

endmodule

// File: rtl/cfs_sync_detect.sv
module cfs_sync_detect
    import cfs_pkg::*;
(
    input  fmt_e fmt_i,
    input  logic rise_i,
    input  logic fs_now_i,
    input  logic fs_prev_i,
    output logic hit_o
);

    always_comb begin
        if (fmt_edge_sync(fmt_i)) begin
            hit_o = rise_i & (fs_now_i ^ fs_prev_i);
        end else begin
            hit_o = rise_i & fs_now_i;
        end
    end

endmodule

// File: rtl/cfs_frame_ctrl.sv
module cfs_frame_ctrl
    import cfs_pkg::*;
#(
    parameter int unsigned LEN_W  = 5,
    parameter int unsigned SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  fmt_e              fmt_i,
    input  logic [LEN_W-1:0]  word_len_i,
    input  logic [SLOT_W-1:0] frame_words_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              fs_now_i,
    input  logic              sync_hit_i,
    output logic              running_o,
    output logic              load_o,
    output logic              shift_o,
    output logic              capture_o,
    output logic              word_done_o,
    output logic              frame_end_o,
    output logic [LEN_W-1:0]  cur_len_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam logic [LEN_W-1:0]  ONE_BIT  = LEN_W'(1);
    localparam logic [SLOT_W-1:0] ONE_SLOT = SLOT_W'(1);

    run_e              state_q;
    logic              pending_q;
    logic [LEN_W-1:0]  bits_left_q;
    logic [SLOT_W-1:0] slot_q;

    logic              last_slot;
    logic              accept;
    logic [SLOT_W-1:0] start_slot;
    logic [SLOT_W-1:0] next_slot;

    function automatic logic [LEN_W-1:0] slot_len(fmt_e f, logic [SLOT_W-1:0] idx,
                                                  logic [LEN_W-1:0] cfg);
        if (f == FMT_ACLINK) begin
            return (idx == '0) ? LEN_W'(AC_TAG_BITS) : LEN_W'(AC_SLOT_BITS);
        end
        return cfg;
    endfunction

    assign running_o   = (state_q == ST_RUN);
    assign capture_o   = rise_i & running_o & ~pending_q;
    assign load_o      = fall_i & running_o & pending_q;
    assign shift_o     = fall_i & running_o & ~pending_q;
    assign word_done_o = capture_o & (bits_left_q == ONE_BIT);
    assign last_slot   = fmt_edge_sync(fmt_i) || (slot_q == (frame_words_i - ONE_SLOT));
    assign frame_end_o = word_done_o & last_slot;
    assign accept      = sync_hit_i & (~running_o | frame_end_o);
    assign start_slot  = fmt_edge_sync(fmt_i) ? {{(SLOT_W-1){1'b0}}, fs_now_i} : '0;
    assign next_slot   = slot_q + ONE_SLOT;
    assign cur_len_o   = bits_left_q;
    assign slot_o      = slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pending_q   <= 1'b0;
            bits_left_q <= '0;
            slot_q      <= '0;
        end else if (accept) begin
            state_q     <= ST_RUN;
            pending_q   <= 1'b1;
            slot_q      <= start_slot;
            bits_left_q <= slot_len(fmt_i, start_slot, word_len_i);
        end else if (frame_end_o) begin
            state_q   <= ST_IDLE;
            pending_q <= 1'b0;
        end else if (word_done_o) begin
            pending_q   <= 1'b1;
            slot_q      <= next_slot;
            bits_left_q <= slot_len(fmt_i, next_slot, word_len_i);
        end else if (capture_o) begin
            bits_left_q <= bits_left_q - ONE_BIT;
        end else if (load_o) begin
            pending_q <= 1'b0;
        end
    end

    // Mid-word sync events must not disturb the bit count.
    assert_sync_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (capture_o && bits_left_q > ONE_BIT) |=>
            (running_o && bits_left_q == $past(bits_left_q) - ONE_BIT));

    assert_idle_sync_starts_R1: assert property (@(posedge clk) disable iff (rst)
        (sync_hit_i && !running_o) |=> (running_o && pending_q));

    assert_slot_in_frame_R1: assert property (@(posedge clk) disable iff (rst)
        (running_o && fmt_i != FMT_I2S) |-> (slot_q < frame_words_i));

    assert_i2s_slot_level_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && fmt_i == FMT_I2S) |=> (slot_q == SLOT_W'($past(fs_now_i))));

endmodule

// File: rtl/cfs_shifter.sv
module cfs_shifter #(
    parameter int unsigned DATA_W = 20,
    parameter int unsigned LEN_W  = 5,
    parameter int unsigned SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              running_i,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              capture_i,
    input  logic              word_done_i,
    input  logic              clear_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              sd_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              sdo_o,
    output logic              tx_ack_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic [SLOT_W-1:0] rx_slot_o
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;

    assign rx_next = {rx_sh[DATA_W-2:0], sd_i};
    assign sdo_o   = tx_sh[DATA_W-1];

    // Transmit: left-align the word at load so the MSB sits on the output.
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            tx_sh <= '0;
        end else if (load_i) begin
            tx_sh <= tx_valid_i ? (tx_data_i << (FULL_LEN - len_i)) : '0;
        end else if (shift_i) begin
            tx_sh <= tx_sh << 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ack_o <= 1'b0;
        end else begin
            tx_ack_o <= load_i & tx_valid_i;
        end
    end

    // Receive: cleared at each word start, so the word lands right-justified.
    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            rx_sh <= '0;
        end else if (capture_i) begin
            rx_sh <= rx_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
            rx_slot_o  <= '0;
        end else begin
            rx_valid_o <= word_done_i;
            if (word_done_i) begin
                rx_data_o <= rx_next;
                rx_slot_o <= slot_i;
            end
        end
    end

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!running_i && !$past(running_i)) |-> !sdo_o);

    assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo_o) |-> $past(load_i || shift_i || clear_i));

    assert_rx_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    assert_ack_after_offer_R7: assert property (@(posedge clk) disable iff (rst)
        tx_ack_o |-> ($past(tx_valid_i) && $past(load_i)));

endmodule

// File: rtl/codec_fsync_slave.sv
module codec_fsync_slave
    import cfs_pkg::*;
#(
    parameter int unsigned DATA_W = 20,
    parameter int unsigned LEN_W  = 5,
    parameter int unsigned SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fmt_i,
    input  logic [LEN_W-1:0]  word_len_i,
    input  logic [SLOT_W-1:0] frame_words_i,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ack_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic [SLOT_W-1:0] rx_slot_o,
    output logic              frame_active_o
);

    fmt_e              fmt;
    line_s             line;
    logic              sync_hit;
    logic              running;
    logic              load;
    logic              shift;
    logic              capture;
    logic              word_done;
    logic              frame_end;
    logic [LEN_W-1:0]  cur_len;
    logic [SLOT_W-1:0] slot;

    assign fmt            = fmt_e'(fmt_i);
    assign frame_active_o = running;

    cfs_line_sampler u_sampler (
        .clk     (clk),
        .rst     (rst),
        .bclk_i  (bclk_i),
        .fsync_i (fsync_i),
        .sdi_i   (sdi_i),
        .line_o  (line)
    );

    cfs_sync_detect u_sync (
        .fmt_i     (fmt),
        .rise_i    (line.rise),
        .fs_now_i  (line.fs_now),
        .fs_prev_i (line.fs_prev),
        .hit_o     (sync_hit)
    );

    cfs_frame_ctrl #(
        .LEN_W  (LEN_W),
        .SLOT_W (SLOT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .fmt_i         (fmt),
        .word_len_i    (word_len_i),
        .frame_words_i (frame_words_i),
        .rise_i        (line.rise),
        .fall_i        (line.fall),
        .fs_now_i      (line.fs_now),
        .sync_hit_i    (sync_hit),
        .running_o     (running),
        .load_o        (load),
        .shift_o       (shift),
        .capture_o     (capture),
        .word_done_o   (word_done),
        .frame_end_o   (frame_end),
        .cur_len_o     (cur_len),
        .slot_o        (slot)
    );

    cfs_shifter #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .SLOT_W (SLOT_W)
    ) u_shift (
        .clk         (clk),
        .rst         (rst),
        .running_i   (running),
        .load_i      (load),
        .shift_i     (shift),
        .capture_i   (capture),
        .word_done_i (word_done),
        .clear_i     (frame_end),
        .len_i       (cur_len),
        .slot_i      (slot),
        .sd_i        (line.sd),
        .tx_data_i   (tx_data_i),
        .tx_valid_i  (tx_valid_i),
        .sdo_o       (sdo_o),
        .tx_ack_o    (tx_ack_o),
        .rx_data_o   (rx_data_o),
        .rx_valid_o  (rx_valid_o),
        .rx_slot_o   (rx_slot_o)
    );

endmodule

// File: tb/codec_fsync_slave_tb_top.sv
`timescale 1ns/1ps
module codec_fsync_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  fmt;
    logic [4:0]  word_len;
    logic [4:0]  frame_words;
    logic        bclk;
    logic        fsync;
    logic        sdi;
    logic        sdo_o;
    logic [19:0] tx_data;
    logic        tx_valid;
    logic        tx_ack_o;
    logic [19:0] rx_data_o;
    logic        rx_valid_o;
    logic [4:0]  rx_slot_o;
    logic        frame_active_o;

    int n_checks = 0;
    int n_errors = 0;
    int ack_exp  = 0;
    int ack_seen = 0;
    bit done     = 1'b0;

    logic [19:0] exp_data[$];
    logic [4:0]  exp_slot[$];
    string       exp_req[$];

    always #10 clk = ~clk;

    codec_fsync_slave dut_i (
        .clk            (clk),
        .rst            (rst),
        .fmt_i          (fmt),
        .word_len_i     (word_len),
        .frame_words_i  (frame_words),
        .bclk_i         (bclk),
        .fsync_i        (fsync),
        .sdi_i          (sdi),
        .sdo_o          (sdo_o),
        .tx_data_i      (tx_data),
        .tx_valid_i     (tx_valid),
        .tx_ack_o       (tx_ack_o),
        .rx_data_o      (rx_data_o),
        .rx_valid_o     (rx_valid_o),
        .rx_slot_o      (rx_slot_o),
        .frame_active_o (frame_active_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] lowmask(input int len);
        return (20'(1) << len) - 20'(1);
    endfunction

    // One bit period: codec drives on the fall, samples our output before the rise.
    task automatic bit_cycle(input logic fs, input logic sd, output logic so);
        @(negedge clk);
        bclk  = 1'b0;
        fsync = fs;
        sdi   = sd;
        repeat (3) @(negedge clk);
        so = sdo_o;
        @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic sync_cycle(input logic fs);
        logic so;
        bit_cycle(fs, 1'b0, so);
    endtask

    // Driver: queues the expected receive item, plays the word, checks the output bits.
    task automatic word_xfer(input int len, input logic [19:0] rxw, input logic [4:0] slot,
                             input logic txv, input logic [19:0] txw,
                             input logic fs_mid, input logic fs_last, input string req);
        logic [19:0] got;
        logic [19:0] want;
        logic        so;
        got = '0;
        exp_data.push_back(rxw & lowmask(len));
        exp_slot.push_back(slot);
        exp_req.push_back(req);
        if (txv) ack_exp++;
        tx_valid = txv;
        tx_data  = txw;
        for (int i = len - 1; i >= 0; i--) begin
            bit_cycle((i == 0) ? fs_last : fs_mid, rxw[i], so);
            got = {got[18:0], so};
        end
        want = txv ? (txw & lowmask(len)) : 20'h0;
        check(got == want, req, "serial output word", {12'h0, got}, {12'h0, want});
        tx_valid = 1'b0;
    endtask

    task automatic idle_check(input string req);
        check(frame_active_o == 1'b0 && sdo_o == 1'b0, req, "idle after frame (active,sdo)",
              {30'h0, frame_active_o, sdo_o}, 32'h0);
        check(exp_data.size() == 0, "R6", "pending receive items", exp_data.size(), 0);
        check(ack_seen == ack_exp, "R7", "transmit acknowledges", ack_seen, ack_exp);
    endtask

    // Monitor: pops expected receive items as the design produces them.
    always @(negedge clk) begin
        if (!rst && rx_valid_o) begin
            if (exp_data.size() == 0) begin
                check(1'b0, "R6", "unexpected receive word", {7'h0, rx_slot_o, rx_data_o}, 0);
            end else begin
                logic [19:0] d;
                logic [4:0]  s;
                string       r;
                d = exp_data.pop_front();
                s = exp_slot.pop_front();
                r = exp_req.pop_front();
                check(rx_data_o == d && rx_slot_o == s, r, "receive word {slot,data}",
                      {7'h0, rx_slot_o, rx_data_o}, {7'h0, s, d});
            end
        end
        if (!rst && tx_ack_o) ack_seen++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (all requirements): actual 100000 cycles, expected earlier finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fmt = 2'd0; word_len = 5'd8; frame_words = 5'd3;
        bclk = 1'b1; fsync = 1'b0; sdi = 1'b0; tx_data = '0; tx_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R9: reset state
        check(frame_active_o == 0 && sdo_o == 0 && rx_valid_o == 0 && tx_ack_o == 0, "R9",
              "reset outputs", {28'h0, frame_active_o, sdo_o, rx_valid_o, tx_ack_o}, 0);
        sync_cycle(1'b0);

        // R1 R5 R6 R7: multi-channel, 3 words of 8 bits
        sync_cycle(1'b1);
        word_xfer(8, 20'hA5, 5'd0, 1'b1, 20'hFFF3C, 1'b0, 1'b0, "R1");
        word_xfer(8, 20'h3C, 5'd1, 1'b1, 20'h81,    1'b0, 1'b0, "R5");
        word_xfer(8, 20'hF0, 5'd2, 1'b1, 20'h7E,    1'b0, 1'b0, "R6");
        idle_check("R8");

        // R7: missing transmit word sends zeros
        sync_cycle(1'b1);
        word_xfer(8, 20'h5A, 5'd0, 1'b1, 20'hC3, 1'b0, 1'b0, "R7");
        word_xfer(8, 20'h01, 5'd1, 1'b0, 20'hFF, 1'b0, 1'b0, "R7");
        word_xfer(8, 20'h80, 5'd2, 1'b1, 20'h99, 1'b0, 1'b0, "R7");
        idle_check("R8");

        // R1: longest word, single-word frame
        word_len = 5'd16; frame_words = 5'd1;
        sync_cycle(1'b1);
        word_xfer(16, 20'hBEEF, 5'd0, 1'b1, 20'h1234, 1'b0, 1'b0, "R1");
        idle_check("R8");

        // R1: shortest word, largest frame
        word_len = 5'd4; frame_words = 5'd16;
        sync_cycle(1'b1);
        for (int w = 0; w < 16; w++) begin
            word_xfer(4, 20'(w ^ 9), 5'(w), 1'b1, 20'(15 - w), 1'b0, 1'b0, "R1");
        end
        idle_check("R8");

        // R4: sync held high through the whole frame is ignored
        word_len = 5'd4; frame_words = 5'd2;
        sync_cycle(1'b1);
        word_xfer(4, 20'h9, 5'd0, 1'b1, 20'h6, 1'b1, 1'b1, "R4");
        word_xfer(4, 20'h6, 5'd1, 1'b1, 20'hA, 1'b1, 1'b0, "R4");
        idle_check("R4");

        // R4: sync on the last bit starts the next frame at once
        word_len = 5'd5; frame_words = 5'd1;
        sync_cycle(1'b1);
        word_xfer(5, 20'h13, 5'd0, 1'b1, 20'h0B, 1'b0, 1'b1, "R4");
        word_xfer(5, 20'h0C, 5'd0, 1'b1, 20'h15, 1'b0, 1'b0, "R4");
        idle_check("R8");

        // R2: AC-link, tag plus two 20-bit slots
        fmt = 2'd1; frame_words = 5'd3;
        sync_cycle(1'b1);
        word_xfer(16, 20'h9C01,  5'd0, 1'b1, 20'hE000,  1'b0, 1'b0, "R2");
        word_xfer(20, 20'hABCDE, 5'd1, 1'b0, 20'h11111, 1'b0, 1'b0, "R2");
        word_xfer(20, 20'h80001, 5'd2, 1'b1, 20'hF0F0F, 1'b0, 1'b0, "R2");
        idle_check("R8");

        // R3: I2S, word select edges
        fmt = 2'd2; word_len = 5'd6;
        sync_cycle(1'b1);
        word_xfer(6, 20'h2D, 5'd1, 1'b1, 20'h33, 1'b1, 1'b0, "R3");
        word_xfer(6, 20'h12, 5'd0, 1'b1, 20'h21, 1'b1, 1'b1, "R3");
        idle_check("R4");
        sync_cycle(1'b0);
        word_xfer(6, 20'h3F, 5'd0, 1'b0, 20'h3F, 1'b0, 1'b0, "R3");
        idle_check("R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule